// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block monitors an already synchronized I2C clock and data pair. It finds START and repeated START conditions and shifts in the first byte that follows each one. It then compares that byte with a programmable own address and, when enabled, with the general call address. The result appears as two hit flags, a direction flag and a two-bit status code. A sticky interrupt request is raised when either address matches.

Software writes an 8-bit setting. Bits 7:1 hold the 7-bit slave address. Bit 0 enables general call recognition. The acknowledge driver and everything after the address byte belong to neighbouring logic. That logic reads the status and takes over from there.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, own_hit, gc_hit, rd_dir, irq and status are all 0.
- R2: A START is sda falling while scl is high. It begins collection of a new address byte and clears own_hit, gc_hit, rd_dir and status.
- R3: The address byte is built from sda as sampled on eight scl rising edges, most significant bit first. When its bits 7:1 equal own_addr[7:1], own_hit is 1. rd_dir takes bit 0, and status is 1 for write (bit 0 = 0) or 2 for read (bit 0 = 1).
- R4: When own_addr[0] is 1, a received byte of 00h sets gc_hit and status 3, and own_hit stays 0. When own_addr[0] is 0, a byte of 00h is not a general call.
- R5: A byte of 01h (general call with read direction) never sets gc_hit.
- R6: When neither address matches, status is 0, both hit flags are 0 and irq stays 0.
- R7: On a match, irq goes to 1 and stays there until irq_clr is pulsed. If a new match and irq_clr arrive in the same cycle, the match wins.
- R8: A STOP (sda rising while scl is high) or a new START before the eighth bit discards the partial byte without any match. After a repeated START, counting begins again from the first bit.
- R9: Bits after the eighth, including the acknowledge slot and data bytes, do not change the hit flags, status or irq until the next START.
- R10: At most one of own_hit and gc_hit is 1 at any time. own_hit implies status 1 or 2, and gc_hit implies status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronized bus clock line |
| sda | input | 1 | Synchronized bus data line |
| own_addr | input | 8 | Own address in bits 7:1, general call enable in bit 0 |
| irq_clr | input | 1 | One-cycle pulse that clears the pending interrupt |
| own_hit | output | 1 | Last address byte matched the own address |
| gc_hit | output | 1 | Last address byte was an enabled general call |
| rd_dir | output | 1 | Direction bit of the last completed address byte |
| status | output | 2 | 0 none, 1 own write, 2 own read, 3 general call |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions check several rules on every cycle. The hit flags are never both set, and each hit flag agrees with the status code. A pending interrupt survives until it is cleared, and it only rises together with a hit. A general call hit only appears when the enable bit was set. A STOP leaves no collection in progress. Other behaviour depends on serial sequences and only the bench scenarios can show it. That includes the exact bit order and the direction capture, aborts by STOP or repeated START partway through a byte, and data bytes after the acknowledge slot that are ignored even when they equal the own address.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W:0]   own_addr,
  input  logic              irq_clr,
  output logic              own_hit,
  output logic              gc_hit,
  output logic              rd_dir,
  output logic [1:0]        status,
  output logic              irq
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  logic              scl_q, sda_q, armed;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] shr;

  wire scl_up  = scl & ~scl_q;
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c  = scl & scl_q & ~sda_q & sda;
  wire last    = armed & scl_up & (cnt == CNT_W'(BYTE_W - 1));

  wire [ADDR_W:0] rx = {shr, sda};
  wire gc_m  = own_addr[0] & (rx == '0);
  wire own_m = ~gc_m & (rx[ADDR_W:1] == own_addr[ADDR_W:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      shr     <= '0;
      own_hit <= 1'b0;
      gc_hit  <= 1'b0;
      rd_dir  <= 1'b0;
      status  <= 2'd0;
    end else if (start_c) begin
      armed   <= 1'b1;
      cnt     <= '0;
      own_hit <= 1'b0;
      gc_hit  <= 1'b0;
      rd_dir  <= 1'b0;
      status  <= 2'd0;
    end else if (stop_c) begin
      armed <= 1'b0;
    end else if (armed && scl_up) begin
      shr <= rx[ADDR_W-1:0];
      cnt <= cnt + 1'b1;
      if (last) begin
        armed   <= 1'b0;
        own_hit <= own_m;
        gc_hit  <= gc_m;
        rd_dir  <= rx[0];
        status  <= gc_m ? 2'd3 : own_m ? (rx[0] ? 2'd2 : 2'd1) : 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   irq <= 1'b0;
    else if (last && (gc_m || own_m)) irq <= 1'b1;
    else if (irq_clr)             irq <= 1'b0;
  end

  a_r10_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({own_hit, gc_hit}));
  a_r10_own_code: assert property (@(posedge clk) disable iff (!rst_n)
    own_hit |-> (status == 2'd1 || status == 2'd2));
  a_r10_gc_code: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> status == 2'd3);
  a_r4_gc_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_hit) |-> $past(own_addr[0]));
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (own_hit || gc_hit));
  a_r8_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !armed);
endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1, irq_clr = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic own_hit, gc_hit, rd_dir, irq;
  logic [1:0] status;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_addr_match u0 (.clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .own_addr(own_addr), .irq_clr(irq_clr), .own_hit(own_hit),
    .gc_hit(gc_hit), .rd_dir(rd_dir), .status(status), .irq(irq));

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); sda = 1'b1; idle(3); scl = 1'b1; idle(3);
    sda = 1'b0; idle(3); scl = 1'b0; idle(3); endtask
  task automatic bus_stop(); sda = 1'b0; idle(3); scl = 1'b1; idle(3);
    sda = 1'b1; idle(3); endtask
  task automatic send_bit(bit b); sda = b; idle(3); scl = 1'b1; idle(3);
    scl = 1'b0; idle(3); endtask
  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic clear_irq(); irq_clr = 1'b1; idle(1); irq_clr = 1'b0; idle(1); endtask

  function automatic logic [1:0] exp_code(logic [7:0] b, logic [7:0] oa);
    if (oa[0] && b == 8'h00) return 2'd3;
    if (b[7:1] == oa[7:1]) return b[0] ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic [7:0] b, logic [1:0] code, logic ei);
    chk({req, " status"}, {6'd0, status}, {6'd0, code});
    chk({req, " own_hit"}, {7'd0, own_hit}, {7'd0, code == 2'd1 || code == 2'd2});
    chk({req, " gc_hit"}, {7'd0, gc_hit}, {7'd0, code == 2'd3});
    chk({req, " irq"}, {7'd0, irq}, {7'd0, ei});
    if (code != 2'd0) chk({req, " rd_dir"}, {7'd0, rd_dir}, {7'd0, b[0]});
  endtask

  initial begin
    logic [7:0] b;
    logic [1:0] c;
    void'($urandom(32'd2024));
    idle(4); rst_n = 1'b1; idle(2);
    chk_all("R1", 8'h00, 2'd0, 1'b0);

    own_addr = 8'hA4;
    bus_start(); send_byte(8'hA4); chk_all("R3 write", 8'hA4, 2'd1, 1'b1);
    send_bit(1'b0); send_byte(8'h55); chk_all("R9 data ignored", 8'hA4, 2'd1, 1'b1);
    idle(2); chk("R7 irq held", {7'd0, irq}, 8'd1);
    clear_irq(); chk("R7 irq cleared", {7'd0, irq}, 8'd0);
    bus_start(); chk_all("R2 start clears", 8'h00, 2'd0, 1'b0);
    send_byte(8'hA5); chk_all("R3 read", 8'hA5, 2'd2, 1'b1);
    bus_stop(); clear_irq();

    bus_start(); send_byte(8'h12); chk_all("R6 miss", 8'h12, 2'd0, 1'b0);
    send_bit(1'b1); send_byte(8'hA4); chk_all("R9 own addr in data", 8'h12, 2'd0, 1'b0);
    bus_stop();

    own_addr = 8'hA5;
    bus_start(); send_byte(8'h00); chk_all("R4 gc", 8'h00, 2'd3, 1'b1);
    bus_stop(); clear_irq();
    bus_start(); send_byte(8'h01); chk_all("R5 gc read", 8'h01, 2'd0, 1'b0);
    bus_stop();
    own_addr = 8'hA4;
    bus_start(); send_byte(8'h00); chk_all("R4 gc disabled", 8'h00, 2'd0, 1'b0);
    bus_stop();

    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop(); idle(4); chk_all("R8 stop abort", 8'h00, 2'd0, 1'b0);
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start(); send_byte(8'hA4); chk_all("R8 restart", 8'hA4, 2'd1, 1'b1);
    bus_stop(); clear_irq();

    for (int k = 0; k < 40; k++) begin
      own_addr = 8'($urandom);
      case ($urandom % 4)
        0: b = {own_addr[7:1], 1'($urandom)};
        1: b = 8'h00;
        2: b = 8'h01;
        default: b = 8'($urandom);
      endcase
      c = exp_code(b, own_addr);
      bus_start(); send_byte(b); chk_all("R3 R4 R5 R6 random", b, c, c != 2'd0);
      send_bit(1'b0);
      if ($urandom % 2) begin
        send_byte(own_addr & 8'hFE);
        chk_all("R9 random data", b, c, c != 2'd0);
      end
      bus_stop(); clear_irq();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule